// File: doc/BRIEF.md
# Transition-Timing Capture Compressor

This block sits behind the input samplers of a timing acquisition channel. It watches a parallel group of lines that have already been reduced to ones and zeros and are sampled once per cycle of the fast internal clock. Capture memory is written only when the sampled vector changes. For each change the block writes two words: the vector held before the change, then the number of sample periods since the previous recorded change. While the lines stay steady nothing is written, so a fixed memory covers a long window at full one-period resolution.

Capture is controlled by a single `run` level. Raising it arms the block: the current sample becomes the reference, the interval timer clears and the write address returns to zero, all without a write. Very long quiet stretches are still timed: when the timer reaches its top value, a pair holding the unchanged vector and the top count is written and timing restarts. Every word carries a tag bit that separates value words from interval words. When fewer than two free locations remain after a pair, writing stops and `full` is raised, so a pair is never split.

The controller has four states. `ST_IDLE` waits with `run` low. Its transition *arm* (run high) goes to `ST_RUN`. `ST_RUN` compares and times. Its transition *record* (a change or timer top) writes the value word and goes to `ST_IVL`, and *stop* (run low) goes to `ST_IDLE`. `ST_IVL` writes the interval word, then takes *resume* to `ST_RUN`, *fill* to `ST_FULL` when room is short, or *stop* to `ST_IDLE`. `ST_FULL` holds with no writes and takes *stop* to `ST_IDLE`.

Top module: `tc_capture`

## Requirements
- R1: After reset, and at any time `run` is low, `mem_we` stays 0 whatever `sample_in` does; `full` is 0 after reset.
- R2: A rise of `run` loads the present registered sample as reference without a write, clears the timer, restarts the address at 0 and clears `full`; the words of a capture go to addresses 0, 1, 2, ... in order.
- R3: A sample that differs from the reference writes a value word holding the pre-change vector, and the interval word follows in the very next cycle at the next address.
- R4: For changes at least two sample periods apart, the interval word holds the distance in sample periods between the two changes; the first one is measured from one period before the arming edge is seen.
- R5: Two writes per recorded change and none while the inputs are steady, so the word count of a capture is twice the number of recorded events.
- R6: After 2^CW-1 periods with no change, a pair with the unchanged vector and interval 2^CW-1 is written and timing restarts from that point.
- R7: The tag `mem_tag` is 0 for value words and 1 for interval words; both are zero-extended to the memory word width.
- R8: After an interval word, if fewer than two locations would remain, no further writes happen and `full` is 1 until the next arm.
- R9: A change that first appears in the cycle the interval word is written is recorded one period later, with its interval counted to that later period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Capture enable; its rise arms the block |
| sample_in | input | W | Digitized input lines |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | AW | Write address, AW = clog2(DEPTH) |
| mem_data | output | DW | Write data, DW = max(W, CW) |
| mem_tag | output | 1 | 0 value word, 1 interval word |
| full | output | 1 | Memory holds no room for another pair |

## Verification
The bench builds the block with a 4-bit input vector, a 3-bit timer (top count 7) and an odd depth of nine words. With this setup the timer top falls inside short gaps, so saturation pairs, a change exactly at the top count and a change one period after a saturation pair are all reached. The memory also fills after four pairs with a single location left over. Forty capture sessions sweep start values, gap lengths from 2 to 16 and change counts from one to six, so some sessions overflow. A directed session places a change in the interval-write cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_IVL  = 2'd2,
        ST_FULL = 2'd3
    } tc_state_e;

    typedef enum logic {
        TAG_VALUE    = 1'b0,
        TAG_INTERVAL = 1'b1
    } tc_tag_e;

    function automatic int tc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tc_sample_reg.sv
module tc_sample_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_in,
    input  logic         load_ref,
    output logic [W-1:0] smp_q,
    output logic [W-1:0] ref_q,
    output logic         differs
);

    // Registered sample and the reference the change detector compares to.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
            ref_q <= '0;
        end else begin
            smp_q <= sample_in;
            if (load_ref) begin
                ref_q <= smp_q;
            end
        end
    end

    assign differs = (smp_q != ref_q);

endmodule

// File: rtl/tc_interval.sv
module tc_interval #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          count_en,
    input  logic          latch,
    output logic          at_limit,
    output logic [CW-1:0] ivl_q
);

    localparam logic [CW-1:0] LIMIT = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    // Periods since the last recorded event; the held interval is the
    // count plus the current period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ivl_q <= '0;
        end else begin
            if (latch) begin
                ivl_q <= cnt_q + 1'b1;
            end
            if (clear) begin
                cnt_q <= '0;
            end else if (count_en && (cnt_q != LIMIT)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign at_limit = (cnt_q == (LIMIT - 1'b1));

endmodule

// File: rtl/tc_wr_ptr.sv
module tc_wr_ptr #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [AW-1:0] ptr_q,
    output logic          room_after
);

    localparam int XW = AW + 2;

    logic [XW-1:0] need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clear) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Used while the interval word goes to ptr_q: a further pair needs
    // addresses ptr_q+1 and ptr_q+2 inside the memory.
    assign need       = XW'(ptr_q) + XW'(3);
    assign room_after = (need <= XW'(DEPTH));

endmodule

// File: rtl/tc_capture.sv
module tc_capture
    import tc_pkg::*;
#(
    parameter  int W     = 8,
    parameter  int CW    = 12,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = tc_max(W, CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [W-1:0]  sample_in,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          mem_tag,
    output logic          full
);

    tc_state_e     state_q, state_d;
    logic [W-1:0]  smp_q, ref_q;
    logic          differs;
    logic          at_limit;
    logic [CW-1:0] ivl_q;
    logic [AW-1:0] ptr_q;
    logic          room_after;
    logic          full_q;

    logic arm_go, record_go, load_ref, cnt_clear, cnt_en, we_int;

    tc_sample_reg #(.W(W)) u_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .load_ref  (load_ref),
        .smp_q     (smp_q),
        .ref_q     (ref_q),
        .differs   (differs)
    );

    tc_interval #(.CW(CW)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .count_en (cnt_en),
        .latch    (record_go),
        .at_limit (at_limit),
        .ivl_q    (ivl_q)
    );

    tc_wr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (arm_go),
        .advance    (we_int),
        .ptr_q      (ptr_q),
        .room_after (room_after)
    );

    // Event decode shared by next-state and output logic.
    assign arm_go    = (state_q == ST_IDLE) && run;
    assign record_go = (state_q == ST_RUN) && run && (differs || at_limit);
    assign load_ref  = arm_go || record_go;
    assign cnt_clear = arm_go || record_go;
    assign cnt_en    = ((state_q == ST_RUN) && run) || (state_q == ST_IVL);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky full flag, cleared by arming.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (arm_go) begin
            full_q <= 1'b0;
        end else if ((state_q == ST_IVL) && !room_after) begin
            full_q <= 1'b1;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (record_go) begin
                    state_d = ST_IVL;
                end
            end
            ST_IVL: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (!room_after) begin
                    state_d = ST_FULL;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_FULL: state_d = run ? ST_FULL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        we_int   = 1'b0;
        mem_tag  = TAG_VALUE;
        mem_data = DW'(ref_q);
        unique case (state_q)
            ST_IDLE: begin
                we_int = 1'b0;
            end
            ST_RUN: begin
                we_int   = record_go;
                mem_tag  = TAG_VALUE;
                mem_data = DW'(ref_q);
            end
            ST_IVL: begin
                we_int   = 1'b1;
                mem_tag  = TAG_INTERVAL;
                mem_data = DW'(ivl_q);
            end
            ST_FULL: begin
                we_int = 1'b0;
            end
            default: we_int = 1'b0;
        endcase
    end

    assign mem_we   = we_int;
    assign mem_addr = ptr_q;
    assign full     = full_q;

endmodule

// File: rtl/tc_capture_chk.sv
module tc_capture_chk #(
    parameter int DW    = 12,
    parameter int AW    = 6,
    parameter int DEPTH = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          mem_tag,
    input logic          full
);

    // R3
    pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_tag) |=> (mem_we && mem_tag));

    // R3
    ivl_after_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_tag) |-> $past(mem_we && !mem_tag));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R8
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_we);

    // R8
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < DEPTH));

    // R4
    ivl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_tag) |-> (mem_data != '0));

    // R1
    value_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_tag) |-> run);

endmodule

bind tc_capture tc_capture_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_tag  (mem_tag),
    .full     (full)
);

// File: tb/test_tc_capture.sv
module test_tc_capture;

    localparam int W     = 4;
    localparam int CW    = 3;
    localparam int DEPTH = 9;
    localparam int AW    = 4;
    localparam int DW    = 4;
    localparam int TOP   = 7;
    localparam int CAP   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [W-1:0]  sample_in = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_tag;
    logic          full;

    always #10 clk = ~clk;

    tc_capture #(.W(W), .CW(CW), .DEPTH(DEPTH)) i_tc_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sample_in (sample_in),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_tag   (mem_tag),
        .full      (full)
    );

    // Write log filled by a memory model.
    int   nw = 0;
    int   log_addr [0:1023];
    int   log_data [0:1023];
    bit   log_tag  [0:1023];

    always @(posedge clk) begin
        if (rst_n && mem_we && nw < 1024) begin
            log_addr[nw] = int'(mem_addr);
            log_data[nw] = int'(mem_data);
            log_tag[nw]  = mem_tag;
            nw = nw + 1;
        end
    end

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected words.
    int e_data [0:127];
    bit e_tag  [0:127];
    bit e_late [0:127];
    int n_e;

    task automatic push(input int d, input bit tg, input bit late);
        if (n_e < 128) begin
            e_data[n_e] = d;
            e_tag[n_e]  = tg;
            e_late[n_e] = late;
            n_e++;
        end
    endtask

    // Stimulus: absolute change times (negedge index after run rise) and values.
    int c_time [0:15];
    int c_val  [0:15];
    int c_n;

    task automatic build_expect(input int v0);
        int tref;
        int cur;
        n_e  = 0;
        tref = -1;
        cur  = v0;
        for (int j = 0; j < c_n; j++) begin
            int  teff;
            bit  late;
            while (c_time[j] - tref > TOP) begin
                push(cur, 1'b0, 1'b0);
                push(TOP, 1'b1, 1'b0);
                tref = tref + TOP;
            end
            late = (c_time[j] - tref == 1);
            teff = late ? c_time[j] + 1 : c_time[j];
            push(cur, 1'b0, late);
            push(teff - tref, 1'b1, late);
            tref = teff;
            cur  = c_val[j];
        end
    endtask

    task automatic session(input int v0);
        int nw0;
        int t;
        int n_exp_w;
        // R1: input activity with run low writes nothing
        @(negedge clk);
        run = 1'b0;
        nw0 = nw;
        for (int k = 0; k < 3; k++) begin
            sample_in = W'(k + v0 + 5);
            @(negedge clk);
        end
        sample_in = W'(v0);
        repeat (3) @(negedge clk);
        chk(nw == nw0, "R1", "writes with run low", nw - nw0, 0);
        build_expect(v0);
        nw0 = nw;
        run = 1'b1;
        t = 0;
        @(negedge clk);
        t = 1;
        // R2: arming clears full
        chk(full == 1'b0, "R2", "full after arm", int'(full), 0);
        for (int j = 0; j < c_n; j++) begin
            repeat (c_time[j] - t) @(negedge clk);
            t = c_time[j];
            sample_in = W'(c_val[j]);
        end
        repeat (3) @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        n_exp_w = (n_e < CAP) ? n_e : CAP;
        // R5: two words per event, none while steady
        chk((nw - nw0) == n_exp_w, "R5", "word count", nw - nw0, n_exp_w);
        for (int i = 0; i < n_exp_w && i < (nw - nw0); i++) begin
            string rq;
            chk(log_addr[nw0 + i] == i, "R2", "address", log_addr[nw0 + i], i);
            chk(log_tag[nw0 + i] == e_tag[i], "R7", "tag", int'(log_tag[nw0 + i]), int'(e_tag[i]));
            if (e_late[i])          rq = "R9";
            else if (!e_tag[i])     rq = "R3";
            else if (e_data[i] == TOP) rq = "R6";
            else                    rq = "R4";
            chk(log_data[nw0 + i] == e_data[i], rq, "word data", log_data[nw0 + i], e_data[i]);
        end
        // R8: full after four pairs in nine words
        chk(full == (n_e >= CAP), "R8", "full flag", int'(full), int'(n_e >= CAP));
    endtask

    task automatic main_flow();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0, "R1", "we in reset", int'(mem_we), 0);
        chk(full == 1'b0, "R1", "full in reset", int'(full), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_we == 1'b0, "R1", "we after reset", int'(mem_we), 0);
        // Sweep of start values, gaps and change counts.
        for (int s = 0; s < 40; s++) begin
            int v;
            int tt;
            v   = s % 16;
            c_n = 1 + (s % 6);
            tt  = -1;
            for (int j = 0; j < c_n; j++) begin
                tt = tt + 2 + ((s * 5 + j * 3) % 15);
                c_time[j] = tt;
                v = (v + 1 + ((s * 7 + j) % 15)) % 16;
                c_val[j] = v;
            end
            session(s % 16);
        end
        // R9: directed change inside the interval-write cycle.
        c_n = 3;
        c_time[0] = 3; c_val[0] = 5;
        c_time[1] = 4; c_val[1] = 9;
        c_time[2] = 8; c_val[2] = 2;
        session(0);
    endtask

    initial begin
        bit wd_expired;
        wd_expired = 1'b0;
        fork
            main_flow();
            begin
                repeat (100000) @(posedge clk);
                wd_expired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_expired) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule